// File: doc/BRIEF.md
# Thread-Tagged First-Level Address Translation Cache

This block is a small, fully associative translation cache for a core that runs two hardware threads. It maps effective page numbers to real page numbers. A lookup presents a thread number and a 64-bit effective address. If an entry matches both the page and the thread, the 50-bit real address comes back in the same cycle. The page size is a fixed 4 KB, and the low 12 address bits pass through without translation.

Every entry carries the number of the thread that installed it, so one thread cannot hit another thread's entries. Two threads that use the same mapping each get their own entry. On a miss the lookup stalls and a request goes out to the second-level translation path. When the response returns, the mapping is installed and the stalled lookup completes with the new translation. A fill goes into the lowest-numbered free entry. When no entry is free, a round-robin pointer chooses the victim. Software can clear every entry, or only one thread's entries, in a single cycle.

Top module: `xlt_l1`

## Requirements
- R1: A lookup that hits raises lk_done_o and lk_hit_o in the same cycle, and drives lk_raddr_o = {stored real page number, lk_eaddr_i[11:0]}.
- R2: A lookup hits only when the entry's thread tag equals lk_tid_i and its page tag equals lk_eaddr_i[63:12]. A page installed by one thread misses for the other thread.
- R3: The same page used by both threads occupies two entries. After both threads have filled it, both threads hit on it.
- R4: A hit issues no second-level request. A miss drives mreq_valid_o from the next cycle, with mreq_tid_o = lookup thread and mreq_epn_o = lk_eaddr_i[63:12].
- R5: On a miss, lk_done_o stays low until fill_valid_i arrives after the request handshake. In the fill cycle, lk_done_o = 1, lk_hit_o = 0 and lk_raddr_o = {fill_rpn_i, lk_eaddr_i[11:0]}. Afterwards the same lookup hits.
- R6: Once raised, mreq_valid_o stays high with a stable mreq_epn_o until it is accepted by mreq_ready_i. It drops in the cycle after acceptance.
- R7: A fill goes into the lowest-numbered invalid entry. When all entries are valid, it replaces the entry at a round-robin pointer. The pointer starts at entry 0 and advances by one on each such replacement.
- R8: A one-cycle pulse on inv_all_i clears every entry. Any lookup from the next cycle on misses.
- R9: A pulse on inv_thr_i clears only the entries whose thread tag equals inv_tid_i. The other thread's entries still hit.
- R10: After reset no entry is valid, and mreq_valid_o and lk_done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request; held until lk_done_o |
| lk_tid_i | input | 1 | Thread number of the lookup |
| lk_eaddr_i | input | 64 | Effective address; held until lk_done_o |
| lk_done_o | output | 1 | Translation result valid this cycle |
| lk_hit_o | output | 1 | Result came from a first-level hit |
| lk_raddr_o | output | 50 | Real address |
| mreq_valid_o | output | 1 | Second-level translation request |
| mreq_ready_i | input | 1 | Second-level path accepts request |
| mreq_tid_o | output | 1 | Thread number of the request |
| mreq_epn_o | output | 52 | Effective page number of the request |
| fill_valid_i | input | 1 | Second-level response valid |
| fill_rpn_i | input | 38 | Real page number of the response |
| inv_all_i | input | 1 | Clear all entries |
| inv_thr_i | input | 1 | Clear entries of one thread |
| inv_tid_i | input | 1 | Thread selected by inv_thr_i |

## Verification
A wrong valid bit, tag or thread field shows up at the very next lookup of the affected page. It appears either as a hit where a miss and a request were due, or as a miss with a stray mreq_valid_o one cycle later. A wrong round-robin pointer or a wrong free-entry choice evicts the wrong page. That surfaces only when the evicted page, or a page that should have been evicted, is looked up again, so the replacement test reads back the pages on both sides of each eviction. A wrongly stored real page number appears in lk_raddr_o in the same cycle as the hit.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } miss_state_e;
endpackage

// File: rtl/xlt_entry_array.sv
module xlt_entry_array #(
  parameter int ENTRIES = 128,
  parameter int EPN_W   = 52,
  parameter int RPN_W   = 38,
  parameter int TID_W   = 1,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TID_W-1:0]   lk_tid_i,
  input  logic [EPN_W-1:0]   lk_epn_i,
  output logic               hit_o,
  output logic [RPN_W-1:0]   hit_rpn_o,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [TID_W-1:0]   wr_tid_i,
  input  logic [EPN_W-1:0]   wr_epn_i,
  input  logic [RPN_W-1:0]   wr_rpn_i,
  input  logic               inv_all_i,
  input  logic               inv_thr_i,
  input  logic [TID_W-1:0]   inv_tid_i,
  output logic [ENTRIES-1:0] valid_o
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] match;
  logic [TID_W-1:0]   tid_q [ENTRIES];
  logic [EPN_W-1:0]   epn_q [ENTRIES];
  logic [RPN_W-1:0]   rpn_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      valid_q[i] <= 1'b0;
      else if (sel)                                     valid_q[i] <= 1'b1;
      else if (inv_all_i || (inv_thr_i && tid_q[i] == inv_tid_i)) valid_q[i] <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (sel) begin
        tid_q[i] <= wr_tid_i;
        epn_q[i] <= wr_epn_i;
        rpn_q[i] <= wr_rpn_i;
      end
    end

    assign match[i] = valid_q[i] && (tid_q[i] == lk_tid_i) && (epn_q[i] == lk_epn_i);
  end

  always_comb begin
    hit_rpn_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_rpn_o = hit_rpn_o | rpn_q[i];
  end

  assign hit_o   = |match;
  assign valid_o = valid_q;

  // R2: thread tag keeps entries private, so at most one entry ever matches
  a_r2_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));

  a_r8_inv_all_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_all_i && !wr_en_i) |=> (valid_q == '0));
endmodule

// File: rtl/xlt_victim_sel.sv
module xlt_victim_sel #(
  parameter int ENTRIES = 128,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               fill_i,
  output logic [IDX_W-1:0]   victim_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             full;

  assign full = &valid_i;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_i[i]) free_idx = IDX_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (fill_i && full)
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  assign victim_o = full ? rr_q : free_idx;

  a_r7_victim_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full |-> !valid_i[victim_o]);
endmodule

// File: rtl/xlt_miss_ctrl.sv
module xlt_miss_ctrl
  import xlt_pkg::*;
#(
  parameter int EPN_W = 52,
  parameter int OFF_W = 12,
  parameter int TID_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [TID_W-1:0] lk_tid_i,
  input  logic [EPN_W-1:0] lk_epn_i,
  input  logic [OFF_W-1:0] lk_off_i,
  input  logic             hit_i,
  input  logic             mreq_ready_i,
  input  logic             fill_valid_i,
  output logic             idle_o,
  output logic             mreq_valid_o,
  output logic             fill_commit_o,
  output logic [TID_W-1:0] cap_tid_o,
  output logic [EPN_W-1:0] cap_epn_o,
  output logic [OFF_W-1:0] cap_off_o
);
  miss_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cap_tid_o <= '0;
      cap_epn_o <= '0;
      cap_off_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (lk_valid_i && !hit_i) begin
          state_q   <= ST_REQ;
          cap_tid_o <= lk_tid_i;
          cap_epn_o <= lk_epn_i;
          cap_off_o <= lk_off_i;
        end
        ST_REQ:  if (mreq_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (fill_valid_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o        = (state_q == ST_IDLE);
  assign mreq_valid_o  = (state_q == ST_REQ);
  assign fill_commit_o = (state_q == ST_WAIT) && fill_valid_i;

  a_r6_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_valid_o && !mreq_ready_i) |=> (mreq_valid_o && $stable(cap_epn_o) && $stable(cap_tid_o)));

  a_r6_req_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_valid_o && mreq_ready_i) |=> !mreq_valid_o);
endmodule

// File: rtl/xlt_l1.sv
module xlt_l1 #(
  parameter int ENTRIES = 128,
  parameter int EA_W    = 64,
  parameter int RA_W    = 50,
  parameter int OFF_W   = 12,
  parameter int THREADS = 2,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int EPN_W  = EA_W - OFF_W,
  localparam int RPN_W  = RA_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [TID_W-1:0] lk_tid_i,
  input  logic [EA_W-1:0]  lk_eaddr_i,
  output logic             lk_done_o,
  output logic             lk_hit_o,
  output logic [RA_W-1:0]  lk_raddr_o,
  output logic             mreq_valid_o,
  input  logic             mreq_ready_i,
  output logic [TID_W-1:0] mreq_tid_o,
  output logic [EPN_W-1:0] mreq_epn_o,
  input  logic             fill_valid_i,
  input  logic [RPN_W-1:0] fill_rpn_i,
  input  logic             inv_all_i,
  input  logic             inv_thr_i,
  input  logic [TID_W-1:0] inv_tid_i
);
  logic               hit;
  logic [RPN_W-1:0]   hit_rpn;
  logic [ENTRIES-1:0] valid;
  logic [IDX_W-1:0]   victim;
  logic               idle, fill_commit;
  logic [TID_W-1:0]   cap_tid;
  logic [EPN_W-1:0]   cap_epn;
  logic [OFF_W-1:0]   cap_off;

  xlt_entry_array #(
    .ENTRIES(ENTRIES), .EPN_W(EPN_W), .RPN_W(RPN_W), .TID_W(TID_W)
  ) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_tid_i  (lk_tid_i),
    .lk_epn_i  (lk_eaddr_i[EA_W-1:OFF_W]),
    .hit_o     (hit),
    .hit_rpn_o (hit_rpn),
    .wr_en_i   (fill_commit),
    .wr_idx_i  (victim),
    .wr_tid_i  (cap_tid),
    .wr_epn_i  (cap_epn),
    .wr_rpn_i  (fill_rpn_i),
    .inv_all_i (inv_all_i),
    .inv_thr_i (inv_thr_i),
    .inv_tid_i (inv_tid_i),
    .valid_o   (valid)
  );

  xlt_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid),
    .fill_i   (fill_commit),
    .victim_o (victim)
  );

  xlt_miss_ctrl #(.EPN_W(EPN_W), .OFF_W(OFF_W), .TID_W(TID_W)) u_miss (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lk_valid_i    (lk_valid_i),
    .lk_tid_i      (lk_tid_i),
    .lk_epn_i      (lk_eaddr_i[EA_W-1:OFF_W]),
    .lk_off_i      (lk_eaddr_i[OFF_W-1:0]),
    .hit_i         (hit),
    .mreq_ready_i  (mreq_ready_i),
    .fill_valid_i  (fill_valid_i),
    .idle_o        (idle),
    .mreq_valid_o  (mreq_valid_o),
    .fill_commit_o (fill_commit),
    .cap_tid_o     (cap_tid),
    .cap_epn_o     (cap_epn),
    .cap_off_o     (cap_off)
  );

  assign lk_hit_o   = idle && lk_valid_i && hit;
  assign lk_done_o  = lk_hit_o || fill_commit;
  assign lk_raddr_o = fill_commit ? {fill_rpn_i, cap_off} : {hit_rpn, lk_eaddr_i[OFF_W-1:0]};
  assign mreq_tid_o = cap_tid;
  assign mreq_epn_o = cap_epn;

  a_r4_no_req_after_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |=> !mreq_valid_o);

  a_r4_req_after_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && lk_valid_i && !hit) |=> mreq_valid_o);

  a_r5_done_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mreq_valid_o && lk_done_o));
endmodule

// File: tb/xlt_l1_bench.sv
`timescale 1ns/1ps
module xlt_l1_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [0:0]  lk_tid = '0;
  logic [63:0] lk_eaddr = '0;
  logic        lk_done, lk_hit;
  logic [49:0] lk_raddr;
  logic        mreq_valid;
  logic        mreq_ready = 1'b0;
  logic [0:0]  mreq_tid;
  logic [51:0] mreq_epn;
  logic        fill_valid = 1'b0;
  logic [37:0] fill_rpn = '0;
  logic        inv_all = 1'b0, inv_thr = 1'b0;
  logic [0:0]  inv_tid = '0;

  int checks = 0, errors = 0;
  bit present [2][40];

  always #2 clk = ~clk;

  xlt_l1 u_xlt_l1 (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_tid_i(lk_tid), .lk_eaddr_i(lk_eaddr),
    .lk_done_o(lk_done), .lk_hit_o(lk_hit), .lk_raddr_o(lk_raddr),
    .mreq_valid_o(mreq_valid), .mreq_ready_i(mreq_ready),
    .mreq_tid_o(mreq_tid), .mreq_epn_o(mreq_epn),
    .fill_valid_i(fill_valid), .fill_rpn_i(fill_rpn),
    .inv_all_i(inv_all), .inv_thr_i(inv_thr), .inv_tid_i(inv_tid)
  );

  function automatic logic [37:0] rpn_of(input logic [51:0] epn);
    return epn[37:0] ^ 38'h2A_5A5C_3961 ^ {epn[51:38], 24'h0};
  endfunction

  function automatic logic [51:0] rand_epn(input int k);
    return 52'h7_1234_0000_0000 + 52'(k) * 52'h1_0003;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [0:0] tid, input logic [63:0] ea, input bit exp_hit, input string req);
    logic [49:0] exp_ra;
    int d;
    exp_ra = {rpn_of(ea[63:12]), ea[11:0]};
    @(negedge clk);
    lk_valid = 1'b1; lk_tid = tid; lk_eaddr = ea;
    #1;
    if (lk_done) begin
      check(exp_hit && lk_hit, {req, " hit/miss (R1 R2)"}, 64'(lk_hit), 64'(exp_hit));
      check(lk_raddr == exp_ra, "R1 hit real address", 64'(lk_raddr), 64'(exp_ra));
      @(negedge clk);
      lk_valid = 1'b0;
      #1;
      check(!mreq_valid, "R4 no request after hit", 64'(mreq_valid), 64'd0);
    end else begin
      check(!exp_hit, {req, " unexpected miss (R2)"}, 64'd0, 64'(exp_hit));
      @(negedge clk); #1;
      check(mreq_valid && mreq_epn == ea[63:12] && mreq_tid == tid, "R4 request on miss",
            {11'(mreq_valid), mreq_tid, mreq_epn}, {11'd1, tid, ea[63:12]});
      d = $urandom % 3;
      repeat (d) begin
        @(negedge clk); #1;
        check(mreq_valid && mreq_epn == ea[63:12] && !lk_done, "R6 request held",
              {11'(mreq_valid), 1'b0, mreq_epn}, {11'd1, 1'b0, ea[63:12]});
      end
      mreq_ready = 1'b1;
      @(negedge clk);
      mreq_ready = 1'b0;
      #1;
      check(!mreq_valid && !lk_done, "R6 request dropped, R5 still stalled",
            64'({mreq_valid, lk_done}), 64'd0);
      d = $urandom % 3;
      repeat (d) begin
        @(negedge clk); #1;
        check(!lk_done, "R5 stalled until fill", 64'(lk_done), 64'd0);
      end
      @(negedge clk);
      fill_valid = 1'b1; fill_rpn = rpn_of(ea[63:12]);
      #1;
      check(lk_done && !lk_hit && lk_raddr == exp_ra, "R5 fill result",
            {12'(lk_done), 2'(lk_hit), lk_raddr}, {12'd1, 2'd0, exp_ra});
      @(negedge clk);
      fill_valid = 1'b0; lk_valid = 1'b0;
    end
  endtask

  task automatic pulse_inv(input bit all, input logic [0:0] tid);
    @(negedge clk);
    inv_all = all; inv_thr = !all; inv_tid = tid;
    @(negedge clk);
    inv_all = 1'b0; inv_thr = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] a, b;
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!mreq_valid && !lk_done, "R10 reset outputs", 64'({mreq_valid, lk_done}), 64'd0);

    a = 64'hFEDC_BA98_7654_3ABC;
    b = 64'h0000_0001_2345_6FFF;
    lookup(1'b0, a, 1'b0, "R10 empty after reset");
    lookup(1'b0, a, 1'b1, "R1 refetch");
    lookup(1'b0, {a[63:12], 12'h001}, 1'b1, "R1 other offset");
    lookup(1'b1, a, 1'b0, "R2 other thread");
    lookup(1'b1, a, 1'b1, "R3 second copy");
    lookup(1'b0, a, 1'b1, "R3 first copy kept");
    lookup(1'b1, b, 1'b0, "R2 thread1 page");
    lookup(1'b0, b, 1'b0, "R2 thread0 on thread1 page");
    pulse_inv(1'b0, 1'b1);
    lookup(1'b0, a, 1'b1, "R9 thread0 survives");
    lookup(1'b0, b, 1'b1, "R9 thread0 page b survives");
    lookup(1'b1, a, 1'b0, "R9 thread1 cleared");
    pulse_inv(1'b1, 1'b0);
    lookup(1'b0, a, 1'b0, "R8 all cleared t0");
    lookup(1'b1, a, 1'b0, "R8 all cleared t1");

    // R7 replacement order: fill entries 0..127 with pages p0..p127
    pulse_inv(1'b1, 1'b0);
    for (int k = 0; k < 128; k++) lookup(1'b0, {52'h00A_0000 + 52'(k), 12'h010}, 1'b0, "R7 fill");
    lookup(1'b0, {52'h00A_0000 + 52'd127, 12'h0}, 1'b1, "R7 last fill");
    lookup(1'b0, {52'h00B_0000, 12'h0}, 1'b0, "R7 new page evicts entry 0");
    lookup(1'b0, {52'h00A_0001, 12'h0}, 1'b1, "R7 p1 kept");
    lookup(1'b0, {52'h00B_0000, 12'h0}, 1'b1, "R7 new page present");
    lookup(1'b0, {52'h00A_0000, 12'h0}, 1'b0, "R7 p0 evicted (refill to entry 1)");
    lookup(1'b0, {52'h00A_0001, 12'h0}, 1'b0, "R7 p1 evicted (refill to entry 2)");
    lookup(1'b0, {52'h00A_0003, 12'h0}, 1'b1, "R7 p3 kept");
    lookup(1'b0, {52'h00A_0002, 12'h0}, 1'b0, "R7 p2 evicted");

    // random phase below capacity, model-checked
    pulse_inv(1'b1, 1'b0);
    for (int t = 0; t < 2; t++) for (int k = 0; k < 40; k++) present[t][k] = 1'b0;
    for (int it = 0; it < 500; it++) begin
      int tid, k, r;
      tid = $urandom % 2;
      k   = $urandom % 40;
      r   = $urandom % 60;
      if (r == 0) begin
        pulse_inv(1'b1, 1'b0);
        for (int t = 0; t < 2; t++) for (int j = 0; j < 40; j++) present[t][j] = 1'b0;
      end else if (r == 1) begin
        pulse_inv(1'b0, 1'(tid));
        for (int j = 0; j < 40; j++) present[tid][j] = 1'b0;
      end else begin
        lookup(1'(tid), {rand_epn(k), 12'($urandom)}, present[tid][k], "R2 random");
        present[tid][k] = 1'b1;
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule